// File: doc/BRIEF.md
# Embedded-Signature Block Watchdog

This monitor sits beside a processor's fetch path and watches every instruction word the processor fetches. Within a branch-free block it keeps a running sum of the fetched instruction words. The compiler places one extra reference word at the close of each block, and a side flag marks that word as a signature rather than an instruction. When the monitor sees the reference word, it compares the word with its running sum. It raises a sticky error if the two differ, and then starts the next block from zero.

Because the reference value travels inside the instruction stream, the monitor needs no table of its own. A jump into the middle of a foreign block does not raise an error at once. The partial sum of the block that was left is completed with the wrong block's words, so the next reference comparison fails. Words fetched while the valid strobe is low, such as during a stall, leave all state untouched.

Top module: `blksig_watchdog`

## Requirements
- R1: After reset, `err_flag` and `check_pulse` are 0 and the running sum is zero. A block fetched directly after reset whose reference word equals the sum of its words produces no error.
- R2: Every cycle with `fetch_vld`=1 and `fetch_is_sig`=0 adds `fetch_word` to the running sum modulo 2^WORD_W. With the 32-bit default, 0xFFFFFFFF followed by 0x00000002 yields 0x00000001.
- R3: Cycles with `fetch_vld`=0 leave the running sum, `err_flag` and `check_pulse` unaffected (`check_pulse` goes or stays 0).
- R4: A cycle with `fetch_vld`=1 and `fetch_is_sig`=1 is a check. `check_pulse` is 1 in the single cycle after each check and 0 otherwise.
- R5: When the reference word differs from the running sum at a check, `err_flag` is 1 from the cycle after that check. A matching check leaves `err_flag` unchanged.
- R6: The reference word is never added to the sum. After every check, whether it passes or fails, the running sum is zero, so a reference word of 0 fetched right after a check passes.
- R7: `err_flag` stays 1 until a cycle with `err_clear`=1. If that cycle holds no failing check, `err_flag` is 0 from the next cycle.
- R8: If a failing check and `err_clear`=1 fall in the same cycle, the failure wins and `err_flag` is 1 afterwards.
- R9: Words taken from another block after an illegal jump accumulate onto the partial sum of the block that was left, and the mismatch is reported at the next check.
- R10: `fetch_is_sig` has no effect while `fetch_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_vld | input | 1 | A word is fetched this cycle |
| fetch_word | input | WORD_W | Fetched instruction or reference word |
| fetch_is_sig | input | 1 | Marks the fetched word as a reference signature |
| err_clear | input | 1 | Synchronous clear of the sticky error |
| err_flag | output | 1 | Sticky signature-mismatch error |
| check_pulse | output | 1 | One-cycle strobe after each comparison |

## Verification
The assertions assume that the strobe and flag inputs are never X once reset is released. They also assume the fetch path delivers each word exactly once per valid cycle, so the running sum depends only on valid cycles. They put no restriction on how checks, stalls and clears are interleaved. The stimulus keeps every input at a defined level at all times. It inserts stalls with the signature flag toggled and issues clears at random points, including the cycle of a failing check. The expected sum is rebuilt in the bench for each block from the words it drives.

// File: rtl/sigwd_pkg.sv
package sigwd_pkg;
  // Per-cycle fetch qualifiers shared by the datapath stages.
  typedef struct packed {
    logic vld;
    logic is_sig;
  } fetch_ctl_t;

  // A valid non-signature word is folded into the sum.
  function automatic logic is_fold(fetch_ctl_t c);
    return c.vld & ~c.is_sig;
  endfunction

  // A valid signature word triggers a comparison.
  function automatic logic is_check(fetch_ctl_t c);
    return c.vld & c.is_sig;
  endfunction
endpackage

// File: rtl/sigwd_rst_sync.sv
module sigwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sigwd_accum.sv
module sigwd_accum
  import sigwd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fetch_ctl_t        ctl,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum_o
);
  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] sum_d;
  logic              sum_en;

  always_comb begin
    sum_en = ctl.vld;
    sum_d  = sum_q;
    if (is_check(ctl))     sum_d = '0;
    else if (is_fold(ctl)) sum_d = sum_q + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  AST_SUM_CLEARED_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.vld && ctl.is_sig) |=> (sum_q == '0)); // R6
  AST_SUM_HOLDS_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.vld |=> $stable(sum_q)); // R3
  AST_SUM_FOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.vld && !ctl.is_sig) |=> (sum_q == $past(sum_q) + $past(word))); // R2
endmodule

// File: rtl/sigwd_compare.sv
module sigwd_compare
  import sigwd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fetch_ctl_t        ctl,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] sum,
  output logic              mismatch_o,
  output logic              pulse_o
);
  logic pulse_q;
  logic pulse_d;
  logic check_now;

  always_comb begin
    check_now  = is_check(ctl);
    mismatch_o = check_now & (word != sum);
    pulse_d    = check_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  AST_PULSE_FOLLOWS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.vld && ctl.is_sig) |=> pulse_q); // R4
  AST_NO_PULSE_WITHOUT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.vld && ctl.is_sig) |=> !pulse_q); // R10
endmodule

// File: rtl/sigwd_err_latch.sv
module sigwd_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_en = set_i | clr_i;
    err_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err_o = err_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> err_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_i) |=> err_q); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !err_q); // R7
endmodule

// File: rtl/blksig_watchdog.sv
module blksig_watchdog
  import sigwd_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              fetch_is_sig,
  input  logic              err_clear,
  output logic              err_flag,
  output logic              check_pulse
);
  logic              rst_n_s;
  fetch_ctl_t        ctl;
  logic [WORD_W-1:0] run_sum;
  logic              miss;

  assign ctl.vld    = fetch_vld;
  assign ctl.is_sig = fetch_is_sig;

  sigwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  sigwd_accum #(.WORD_W(WORD_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ctl   (ctl),
    .word  (fetch_word),
    .sum_o (run_sum)
  );

  sigwd_compare #(.WORD_W(WORD_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ctl        (ctl),
    .word       (fetch_word),
    .sum        (run_sum),
    .mismatch_o (miss),
    .pulse_o    (check_pulse)
  );

  sigwd_err_latch u_err (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set_i (miss),
    .clr_i (err_clear),
    .err_o (err_flag)
  );

  AST_ERR_RISE_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(err_flag) |-> check_pulse); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (check_pulse && !$past(fetch_vld && fetch_is_sig)) |-> 1'b0); // R4
endmodule

// File: tb/blksig_watchdog_test.sv
`timescale 1ns/1ps
module blksig_watchdog_test;
  logic        clk;
  logic        rst_n;
  logic        fetch_vld;
  logic [31:0] fetch_word;
  logic        fetch_is_sig;
  logic        err_clear;
  logic        err_flag;
  logic        check_pulse;

  int checks;
  int failures;
  bit done;

  logic [31:0] m_sum;
  logic        m_err;
  logic        m_pulse;
  int          seed_sink;

  blksig_watchdog #(.WORD_W(32), .SYNC_STAGES(2)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_vld    (fetch_vld),
    .fetch_word   (fetch_word),
    .fetch_is_sig (fetch_is_sig),
    .err_clear    (err_clear),
    .err_flag     (err_flag),
    .check_pulse  (check_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] block_sum(input logic [31:0] a, input logic [31:0] b);
    return a + b;
  endfunction

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge; check outputs at the next falling edge.
  task automatic step(input string tag, input logic vld, input logic [31:0] w,
                      input logic sig, input logic clr);
    logic miss;
    fetch_vld    = vld;
    fetch_word   = w;
    fetch_is_sig = sig;
    err_clear    = clr;
    miss    = vld && sig && (w != m_sum);
    m_pulse = vld && sig;
    if (miss)     m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    if (vld && sig)       m_sum = '0;
    else if (vld && !sig) m_sum = block_sum(m_sum, w);
    @(negedge clk);
    check_bit(tag, "check_pulse", check_pulse, m_pulse);
    check_bit(tag, "err_flag", err_flag, m_err);
  endtask

  task automatic word_in(input string tag, input logic [31:0] w);
    step(tag, 1'b1, w, 1'b0, 1'b0);
  endtask

  task automatic sig_in(input string tag, input logic [31:0] w);
    step(tag, 1'b1, w, 1'b1, 1'b0);
  endtask

  task automatic idle(input string tag, input logic sig);
    step(tag, 1'b0, 32'hDEAD_BEEF, sig, 1'b0);
  endtask

  task automatic clear(input string tag);
    step(tag, 1'b0, 32'h0, 1'b0, 1'b1);
  endtask

  initial begin
    logic [31:0] s;
    logic [31:0] w;
    seed_sink = $urandom(32'h1357_2468);
    checks = 0; failures = 0; done = 0;
    m_sum = '0; m_err = 1'b0; m_pulse = 1'b0;
    rst_n = 1'b0; fetch_vld = 1'b0; fetch_word = '0; fetch_is_sig = 1'b0; err_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and a clean first block
    check_bit("R1", "err_flag after reset", err_flag, 1'b0);
    check_bit("R1", "check_pulse after reset", check_pulse, 1'b0);
    word_in("R1", 32'h0000_0010);
    word_in("R1", 32'h0000_0020);
    sig_in("R1", 32'h0000_0030);
    check_bit("R1", "legal first block passes", err_flag, 1'b0);

    // R2: wrap modulo 2^32
    word_in("R2", 32'hFFFF_FFFF);
    word_in("R2", 32'h0000_0002);
    sig_in("R2", 32'h0000_0001);
    check_bit("R2", "wrapped sum matches", err_flag, 1'b0);

    // R3, R10: stalls with the signature flag high change nothing
    word_in("R3", 32'h0000_0100);
    idle("R10", 1'b1);
    idle("R3", 1'b0);
    idle("R10", 1'b1);
    word_in("R3", 32'h0000_0200);
    sig_in("R3", 32'h0000_0300);
    check_bit("R3", "stall did not disturb sum", err_flag, 1'b0);

    // R6: reference word not added; sum zero after a passing check
    sig_in("R6", 32'h0000_0000);
    check_bit("R6", "empty block after check passes", err_flag, 1'b0);

    // R4, R5: one corrupted word fails
    word_in("R5", 32'h1111_1111);
    word_in("R5", 32'h2222_2223);
    sig_in("R5", 32'h3333_3333);
    check_bit("R5", "corrupted block fails", err_flag, 1'b1);
    idle("R4", 1'b0);
    check_bit("R4", "pulse lasts one cycle", check_pulse, 1'b0);

    // R7: sticky across a passing block, then cleared
    word_in("R7", 32'h0000_0005);
    sig_in("R7", 32'h0000_0005);
    check_bit("R7", "error stays set", err_flag, 1'b1);
    clear("R7");
    check_bit("R7", "clear drops error", err_flag, 1'b0);

    // R6: sum zero after a failing check
    word_in("R6", 32'h0000_0007);
    sig_in("R6", 32'h0000_0008);
    clear("R6");
    sig_in("R6", 32'h0000_0000);
    check_bit("R6", "sum reset after failed check", err_flag, 1'b0);

    // R8: failing check together with clear
    word_in("R8", 32'h0000_0001);
    step("R8", 1'b1, 32'h0000_0002, 1'b1, 1'b1);
    check_bit("R8", "failure beats clear", err_flag, 1'b1);
    clear("R8");

    // R9: jump from the middle of block A into the middle of block B
    word_in("R9", 32'h0000_1000);
    word_in("R9", 32'h0000_2000);
    word_in("R9", 32'h0000_0030);
    word_in("R9", 32'h0000_0040);
    sig_in("R9", 32'h0000_00A0);
    check_bit("R9", "bad jump caught at next check", err_flag, 1'b1);
    clear("R9");

    // Random blocks
    for (int b = 0; b < 300; b++) begin
      int len;
      len = 1 + int'($urandom_range(7));
      s = '0;
      for (int k = 0; k < len; k++) begin
        w = $urandom();
        s = s + w;
        word_in("R2", w);
        if ($urandom_range(3) == 0) idle("R3", 1'($urandom_range(1)));
      end
      if ($urandom_range(4) == 0) s = s ^ (32'h1 << $urandom_range(31));
      if ($urandom_range(9) == 0) step("R8", 1'b1, s, 1'b1, 1'b1);
      else                        sig_in("R5", s);
      if ($urandom_range(5) == 0) clear("R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule